// File: doc/BRIEF.md
# ALU-Shifter Function Unit

This block is the purely combinational execution core of a small datapath. A 4-bit function code picks one of fifteen operations on two n-bit operands, A and B (n defaults to 16). The same code drives an adder, a bitwise logic unit and a one-position shifter. An output multiplexer then picks which of these produces the result F. Four status flags come with every result: carry, overflow, negative and zero.

The adder always adds A to a second operand Y and a carry-in. Y is one of four variants of B: zero, B, the inverse of B, or all ones. Function bits 2:1 choose Y and function bit 0 is the carry-in. This arrangement yields increment, add, subtract, decrement and transfer from a single adder. The shifter acts on B alone and fills the vacated bit with zero. There are no registers, so any change at the inputs shows at the outputs within the same cycle.

Top module: `alu_shift_unit`

## Requirements
- R1: For function codes 0000 to 0111, F equals A + Y + fs[0] modulo 2^n. Y is chosen by fs[2:1]: 00 gives zero, 01 gives B, 10 gives ~B and 11 gives all ones. The eight codes in order therefore give A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1 and A.
- R2: For codes 0000 to 0111, C equals the carry out of bit n-1 of that addition.
- R3: For codes 0000 to 0111, V is 1 exactly when A and Y share a sign bit and the sign bit of F differs from it (two's-complement overflow).
- R4: The logic codes and their results are: 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Code 1100 passes B unchanged. Code 1101 shifts B right by one position and puts zero in bit n-1. Code 1110 shifts B left by one position and puts zero in bit 0.
- R6: Code 1111 gives F = 0 for any A and B.
- R7: N equals bit n-1 of F for every code.
- R8: Z is 1 exactly when every bit of F is 0, for every code.
- R9: C and V are 0 whenever fs[3] is 1 (all logic, shift and unused codes).
- R10: F and all four flags follow a change of A, B or the function code without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fs_i | input | 4 | Function code selecting the operation |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| f_o | output | WIDTH | Result |
| c_o | output | 1 | Carry out of the adder (0 for non-arithmetic codes) |
| v_o | output | 1 | Signed overflow of the adder (0 for non-arithmetic codes) |
| n_o | output | 1 | Sign bit of the result |
| z_o | output | 1 | Result-is-zero flag |

## Verification
Each of the sixteen codes is applied to operands chosen so that the code can be told apart from its neighbours. For example, B is nonzero where codes 0000 and 0111 must ignore it, and bit patterns are asymmetric so that AND, OR and XOR give distinct words. The arithmetic cases cross the signed boundary in both directions, covering 7FFF+1, 7FFF+0+1 and 8000-1. They also wrap through zero with a carry, so that V and C are each seen set and clear on their own. The shift cases use a B with both end bits set, which shows the zero fill and the lost bit at each end. Code 1111 and NOT of all ones check that Z is raised for results that are not arithmetic. A final step changes an operand with no clock edge in between and checks the new result.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_INV = 2'b11
    } logic_op_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_NONE  = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'b00,
        YS_B    = 2'b01,
        YS_BINV = 2'b10,
        YS_ONES = 2'b11
    } ysel_e;

endpackage

// File: rtl/fu_arith.sv
module fu_arith
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       ysel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] g_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_op;
    logic [WIDTH:0]   sum_w;

    always_comb begin
        unique case (ysel_e'(ysel_i))
            YS_ZERO: y_op = '0;
            YS_B:    y_op = b_i;
            YS_BINV: y_op = ~b_i;
            YS_ONES: y_op = '1;
            default: y_op = '0;
        endcase
        sum_w  = {1'b0, a_i} + {1'b0, y_op} + {{WIDTH{1'b0}}, cin_i};
        g_o    = sum_w[MSB:0];
        cout_o = sum_w[WIDTH];
        ovf_o  = (a_i[MSB] == y_op[MSB]) && (sum_w[MSB] != a_i[MSB]);

        if (ysel_i == 2'b00 && !cin_i) begin
            AST_ZERO_Y_IDENT: assert (g_o == a_i && !cout_o && !ovf_o); // R2
        end
        if (ysel_i == 2'b11 && cin_i) begin
            AST_ONES_Y_IDENT: assert (g_o == a_i && cout_o); // R1
        end
    end
endmodule

// File: rtl/fu_logic.sv
module fu_logic
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (logic_op_e'(op_i))
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_INV:  res_o = ~a_i;
            default: res_o = '0;
        endcase

        if (op_i == 2'b11) begin
            AST_INVERT_COMPLEMENT: assert ((res_o ^ a_i) == {WIDTH{1'b1}}); // R4
        end
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic FILL = 1'b0;

    always_comb begin
        unique case (shift_op_e'(op_i))
            SH_PASS:  res_o = b_i;
            SH_RIGHT: res_o = {FILL, b_i[MSB:1]};
            SH_LEFT:  res_o = {b_i[MSB-1:0], FILL};
            SH_NONE:  res_o = '0;
            default:  res_o = '0;
        endcase

        if (op_i == 2'b01) begin
            AST_FILL_RIGHT: assert (res_o[MSB] == 1'b0); // R5
        end
        if (op_i == 2'b10) begin
            AST_FILL_LEFT: assert (res_o[0] == 1'b0); // R5
        end
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       fs_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] f_o,
    output logic             c_o,
    output logic             v_o,
    output logic             n_o,
    output logic             z_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] arith_g;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] logic_g;
    logic [WIDTH-1:0] shift_h;
    logic             sel_logic;
    logic             sel_shift;
    logic [WIDTH-1:0] g_mux;

    fu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .ysel_i (fs_i[2:1]),
        .cin_i  (fs_i[0]),
        .g_o    (arith_g),
        .cout_o (arith_c),
        .ovf_o  (arith_v)
    );

    fu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (fs_i[1:0]),
        .res_o (logic_g)
    );

    fu_shift #(.WIDTH(WIDTH)) u_shift (
        .b_i   (b_i),
        .op_i  (fs_i[1:0]),
        .res_o (shift_h)
    );

    always_comb begin
        sel_logic = fs_i[3];
        sel_shift = fs_i[3] & fs_i[2];
        g_mux     = sel_logic ? logic_g : arith_g;
        f_o       = sel_shift ? shift_h : g_mux;
        c_o       = sel_logic ? 1'b0 : arith_c;
        v_o       = sel_logic ? 1'b0 : arith_v;
        n_o       = f_o[MSB];
        z_o       = (f_o == '0);

        if (fs_i == 4'b1111) begin
            AST_UNUSED_ZERO: assert (f_o == '0 && z_o && !n_o); // R6
        end
    end
endmodule

// File: tb/alu_shift_unit_test.sv
module alu_shift_unit_test;
    localparam int W  = 16;
    localparam int NV = 20;

    logic         clk;
    logic [3:0]   fs;
    logic [W-1:0] a, b;
    logic [W-1:0] f;
    logic         c, v, n, z;
    int           errors = 0;
    int           checks = 0;
    bit           done   = 0;

    alu_shift_unit #(.WIDTH(W)) uut (
        .fs_i(fs), .a_i(a), .b_i(b),
        .f_o(f), .c_o(c), .v_o(v), .n_o(n), .z_o(z)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    // {fs, a, b, expected f, expected {c,v,n,z}}
    localparam logic [55:0] VEC [NV] = '{
        {4'h0, 16'h1234, 16'hFFFF, 16'h1234, 4'b0000},
        {4'h1, 16'h7FFF, 16'h0000, 16'h8000, 4'b0110},
        {4'h2, 16'hFFFF, 16'h0001, 16'h0000, 4'b1001},
        {4'h3, 16'h0001, 16'h0002, 16'h0004, 4'b0000},
        {4'h4, 16'h0005, 16'h0003, 16'h0001, 4'b1000},
        {4'h5, 16'h0005, 16'h0005, 16'h0000, 4'b1001},
        {4'h5, 16'h8000, 16'h0001, 16'h7FFF, 4'b1100},
        {4'h6, 16'h0000, 16'h5555, 16'hFFFF, 4'b0010},
        {4'h7, 16'hABCD, 16'h1111, 16'hABCD, 4'b1010},
        {4'h8, 16'hF0F0, 16'hFF00, 16'hF000, 4'b0010},
        {4'h9, 16'hF0F0, 16'h0F00, 16'hFFF0, 4'b0010},
        {4'hA, 16'hFFFF, 16'h00FF, 16'hFF00, 4'b0010},
        {4'hB, 16'h00FF, 16'h1234, 16'hFF00, 4'b0010},
        {4'hC, 16'h0001, 16'h8001, 16'h8001, 4'b0010},
        {4'hD, 16'hFFFF, 16'h8001, 16'h4000, 4'b0000},
        {4'hE, 16'hFFFF, 16'h8001, 16'h0002, 4'b0000},
        {4'hF, 16'hFFFF, 16'hFFFF, 16'h0000, 4'b0001},
        {4'hB, 16'hFFFF, 16'h0000, 16'h0000, 4'b0001},
        {4'h3, 16'h7FFF, 16'h0000, 16'h8000, 4'b0110},
        {4'h2, 16'h7FFF, 16'h0001, 16'h8000, 4'b0110}
    };

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string f_req(input logic [3:0] code);
        if (!code[3])             return "R1";
        else if (!code[2])        return "R4";
        else if (code != 4'hF)    return "R5";
        else                      return "R6";
    endfunction

    initial begin
        fs = 4'h0; a = '0; b = '0;
        @(negedge clk);
        // idle state: zero inputs give a zero result with only Z set
        chk("R8", "idle z", {15'd0, z}, 16'd1);
        chk("R1", "idle f", f, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1;
            {fs, a, b} = VEC[i][55:20];
            @(negedge clk);
            chk(f_req(fs), $sformatf("vec%0d f", i), f, VEC[i][19:4]);
            chk(fs[3] ? "R9" : "R2", $sformatf("vec%0d c", i), {15'd0, c}, {15'd0, VEC[i][3]});
            chk(fs[3] ? "R9" : "R3", $sformatf("vec%0d v", i), {15'd0, v}, {15'd0, VEC[i][2]});
            chk("R7", $sformatf("vec%0d n", i), {15'd0, n}, {15'd0, VEC[i][1]});
            chk("R8", $sformatf("vec%0d z", i), {15'd0, z}, {15'd0, VEC[i][0]});
        end

        // R10: result follows an operand change with no clock edge between
        @(negedge clk);
        fs = 4'h2; a = 16'h0010; b = 16'h0020;
        #1;
        chk("R10", "add first", f, 16'h0030);
        b = 16'h0001;
        #1;
        chk("R10", "add follow", f, 16'h0011);
        fs = 4'hD;
        #1;
        chk("R10", "code follow", f, 16'h0000);
        chk("R10", "z follow", {15'd0, z}, 16'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule